// File: doc/BRIEF.md
# I2C Slave Disable Sequencer

This block sits between the software enable bit of an I2C controller and the controller's slave engine. When software clears the enable bit, the block does not switch the core off at once. It enters a drain phase and waits for a point on the bus where shutdown is safe. During that phase, if the slave engine is involved in a transfer, the block asks the engine to answer with NACK.

When the core-enable output finally drops, the block records two facts about the shutdown. The first is whether a slave transfer was cut short. The second is whether a slave-receiver transfer had already reached its data phase, which means received data was lost. Software reads these facts, with the enable state, from a 32-bit read-only status word. The abort flags are only meaningful once the enable bit of that word reads 0.

If software sets the enable bit again before the drain ends, the shutdown is abandoned. The core stays enabled and nothing is recorded.

Top module: `i2c_disable_seq`

## Requirements
- R1: During and after reset, `coreEnable` and `forceNack` are 0 and `statusWord` is all zeros.
- R2: `statusWord` bits 31:3 always read 0, and bit 0 always equals `coreEnable`.
- R3: When `swEnable` is sampled as 1 while `coreEnable` is 0, `coreEnable` reads 1 after that clock edge, and status bits 2:1 are cleared at the same edge.
- R4: Whenever `coreEnable` is 1, status bits 2:1 read 0.
- R5: When `swEnable` is sampled as 0 while the core is running, a drain begins and `coreEnable` stays 1. It falls at the first later edge at which a completion event is sampled. A completion event is `stopSeen`, `busIdle`, or `byteDone` while `forceNack` is high.
- R6: `forceNack` is high only during a drain. It is high once slave activity (`slvAddrPhase`, `slvTxAddr` or `slvRxData`) has been seen in the request cycle or at any later point of that drain.
- R7: Status bit 1 (aborted while busy) is set when `coreEnable` falls if slave activity was seen at any point from the request cycle to the completion cycle. This includes a drain that ends on STOP before the NACK was issued.
- R8: Status bit 2 (receive data lost) is set when `coreEnable` falls if `slvRxData` was seen in that same window.
- R9: A disable that ends with no slave activity seen, whether the bus was idle or another master was active, leaves bits 2:1 at 0.
- R10: If `swEnable` returns to 1 during a drain, the drain is cancelled. `coreEnable` stays 1, `forceNack` drops, and no flag is recorded for it.
- R11: While `coreEnable` stays 0, bits 2:1 hold their value regardless of the slave strobes, until `swEnable` is set to 1 again.
- R12: `byteDone` ends a drain only while `forceNack` is high. In a drain with no NACK it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| swEnable | input | 1 | Software enable bit |
| slvAddrPhase | input | 1 | Slave engine is receiving an address byte |
| slvTxAddr | input | 1 | Address byte of a slave-transmitter transfer in progress |
| slvRxData | input | 1 | Matching slave-receiver transfer has entered its data phase |
| byteDone | input | 1 | A byte on the bus has completed |
| stopSeen | input | 1 | STOP condition detected |
| busIdle | input | 1 | Bus is idle |
| coreEnable | output | 1 | Delayed core enable |
| forceNack | output | 1 | Request to NACK the ongoing slave transfer |
| statusWord | output | 32 | Bit 0 enable state, bit 1 aborted-while-busy, bit 2 receive-data-lost, others 0 |

## Verification
The following properties are checked on every cycle:
- the zero upper bits and the mirroring of bit 0;
- cleared flags while the core runs;
- no NACK request while the core is off;
- the rule that the enable may only fall right after a sampled completion event;
- prompt enable on request;
- the hold of the flags while the core is off.

Other behaviour depends on a history of strobes, and only the bench's scenarios show it. This covers the flag values recorded for each kind of shutdown, the STOP-before-NACK case, the cancellation of a drain, and the fact that `byteDone` is ignored when no NACK is pending.

// File: rtl/i2c_disable_seq_pkg.sv
package i2c_disable_seq_pkg;

  // Status word bit positions (software decodes these)
  localparam int unsigned EnBit   = 0;
  localparam int unsigned BusyBit = 1;
  localparam int unsigned LostBit = 2;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic enableRise;   // core goes from off to running
    logic startDrain;   // disable request accepted this cycle
    logic draining;     // currently in drain phase
    logic finishDrain;  // drain completes this cycle, core turns off
    logic cancelDrain;  // software re-enabled during drain
  } seqStrobes_t;

endpackage

// File: rtl/i2c_disable_ctl.sv
module i2c_disable_ctl
  import i2c_disable_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swEnable,
  input  logic        byteDone,
  input  logic        stopSeen,
  input  logic        busIdle,
  input  logic        busyNow,
  output seqStrobes_t strobes,
  output logic        coreEnable,
  output logic        forceNack
);

  seqState_e state, stateNext;
  logic      drainDone;

  assign forceNack = (state == ST_DRAIN) && busyNow;
  assign drainDone = stopSeen || busIdle || (byteDone && forceNack);

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_OFF: begin
        if (swEnable) begin
          stateNext          = ST_RUN;
          strobes.enableRise = 1'b1;
        end
      end
      ST_RUN: begin
        if (!swEnable) begin
          stateNext          = ST_DRAIN;
          strobes.startDrain = 1'b1;
        end
      end
      ST_DRAIN: begin
        strobes.draining = 1'b1;
        if (swEnable) begin
          stateNext           = ST_RUN;
          strobes.cancelDrain = 1'b1;
        end else if (drainDone) begin
          stateNext           = ST_OFF;
          strobes.finishDrain = 1'b1;
        end
      end
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  assign coreEnable = (state != ST_OFF);

endmodule

// File: rtl/i2c_disable_dp.sv
module i2c_disable_dp
  import i2c_disable_seq_pkg::*;
#(
  parameter int unsigned STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strobes,
  input  logic                coreEnable,
  input  logic                slvAddrPhase,
  input  logic                slvTxAddr,
  input  logic                slvRxData,
  output logic                busyNow,
  output logic [STATUS_W-1:0] statusWord
);

  localparam int unsigned FlagCount = 2;
  localparam int unsigned ResvLo    = LostBit + 1;

  logic slvActive;
  logic busyAcc, lostAcc;
  logic [FlagCount-1:0] flagReg;   // [1] lost, [0] busy

  assign slvActive = slvAddrPhase || slvTxAddr || slvRxData;
  assign busyNow   = busyAcc || slvActive;

  // Accumulate slave involvement over the drain window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyAcc <= 1'b0;
      lostAcc <= 1'b0;
    end else if (strobes.cancelDrain || strobes.finishDrain || strobes.enableRise) begin
      busyAcc <= 1'b0;
      lostAcc <= 1'b0;
    end else if (strobes.startDrain) begin
      busyAcc <= slvActive;
      lostAcc <= slvRxData;
    end else if (strobes.draining) begin
      busyAcc <= busyAcc || slvActive;
      lostAcc <= lostAcc || slvRxData;
    end
  end

  // Latch flags when core turns off; clear on re-enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg <= '0;
    end else if (strobes.enableRise) begin
      flagReg <= '0;
    end else if (strobes.finishDrain) begin
      flagReg[0] <= busyAcc || slvActive;
      flagReg[1] <= lostAcc || slvRxData;
    end
  end

  generate
    for (genvar b = 0; b < STATUS_W; b++) begin : g_status
      if (b == EnBit) begin : g_en
        assign statusWord[b] = coreEnable;
      end else if (b == BusyBit) begin : g_busy
        assign statusWord[b] = flagReg[0];
      end else if (b == LostBit) begin : g_lost
        assign statusWord[b] = flagReg[1];
      end else begin : g_resv
        assign statusWord[b] = (b >= ResvLo) ? 1'b0 : 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/i2c_disable_seq.sv
module i2c_disable_seq
  import i2c_disable_seq_pkg::*;
#(
  parameter int unsigned STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                swEnable,
  input  logic                slvAddrPhase,
  input  logic                slvTxAddr,
  input  logic                slvRxData,
  input  logic                byteDone,
  input  logic                stopSeen,
  input  logic                busIdle,
  output logic                coreEnable,
  output logic                forceNack,
  output logic [STATUS_W-1:0] statusWord
);

  seqStrobes_t strobes;
  logic        busyNow;

  i2c_disable_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .swEnable   (swEnable),
    .byteDone   (byteDone),
    .stopSeen   (stopSeen),
    .busIdle    (busIdle),
    .busyNow    (busyNow),
    .strobes    (strobes),
    .coreEnable (coreEnable),
    .forceNack  (forceNack)
  );

  i2c_disable_dp #(.STATUS_W(STATUS_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .coreEnable   (coreEnable),
    .slvAddrPhase (slvAddrPhase),
    .slvTxAddr    (slvTxAddr),
    .slvRxData    (slvRxData),
    .busyNow      (busyNow),
    .statusWord   (statusWord)
  );

endmodule

// File: rtl/i2c_disable_seq_chk.sv
module i2c_disable_seq_chk #(
  parameter int unsigned STATUS_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                swEnable,
  input logic                byteDone,
  input logic                stopSeen,
  input logic                busIdle,
  input logic                coreEnable,
  input logic                forceNack,
  input logic [STATUS_W-1:0] statusWord
);

  assert_status_layout_R2: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[STATUS_W-1:3] == '0) && (statusWord[0] == coreEnable));

  assert_flags_clear_running_R4: assert property (@(posedge clk) disable iff (!rstN)
    coreEnable |-> (statusWord[2:1] == 2'b00));

  assert_no_nack_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !coreEnable |-> !forceNack);

  assert_fall_after_event_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreEnable) |-> ($past(stopSeen || busIdle || (byteDone && forceNack)) && !$past(swEnable)));

  assert_prompt_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!coreEnable && swEnable) |=> coreEnable);

  assert_cancel_keeps_on_R10: assert property (@(posedge clk) disable iff (!rstN)
    (coreEnable && swEnable) |=> coreEnable);

  assert_flags_hold_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!coreEnable && $past(!coreEnable)) |-> $stable(statusWord[2:1]));

endmodule

bind i2c_disable_seq i2c_disable_seq_chk #(.STATUS_W(STATUS_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .swEnable   (swEnable),
  .byteDone   (byteDone),
  .stopSeen   (stopSeen),
  .busIdle    (busIdle),
  .coreEnable (coreEnable),
  .forceNack  (forceNack),
  .statusWord (statusWord)
);

// File: tb/i2c_disable_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_disable_seq_tb_top;

  localparam int unsigned StatusW = 32;
  localparam int unsigned NumVec  = 18;

  logic clk = 1'b0;
  logic rstN;
  logic swEnable, slvAddrPhase, slvTxAddr, slvRxData, byteDone, stopSeen, busIdle;
  logic coreEnable, forceNack;
  logic [StatusW-1:0] statusWord;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  i2c_disable_seq #(.STATUS_W(StatusW)) dut_i (
    .clk(clk), .rstN(rstN), .swEnable(swEnable),
    .slvAddrPhase(slvAddrPhase), .slvTxAddr(slvTxAddr), .slvRxData(slvRxData),
    .byteDone(byteDone), .stopSeen(stopSeen), .busIdle(busIdle),
    .coreEnable(coreEnable), .forceNack(forceNack), .statusWord(statusWord)
  );

  // Vector: {sw,addr,tx,rx,byte,stop,idle} {core,nack,lost,busy} {tag}
  localparam logic [14:0] VEC [NumVec] = '{
    {7'b1000001, 4'b1000, 4'd3},   // R3 enable from off
    {7'b1100000, 4'b1000, 4'd4},   // R4 running, activity, no flags
    {7'b0100000, 4'b1100, 4'd5},   // R5/R6 request in address phase
    {7'b0001000, 4'b1100, 4'd6},   // R6 data phase entered
    {7'b0000010, 4'b0011, 4'd7},   // R7/R8 STOP before NACK
    {7'b0101000, 4'b0011, 4'd11},  // R11 flags hold while off
    {7'b1000000, 4'b1000, 4'd3},   // R3 re-enable clears flags
    {7'b0000000, 4'b1000, 4'd5},   // R5 drain without activity
    {7'b0000100, 4'b1000, 4'd12},  // R12 byteDone ignored, no NACK
    {7'b0000001, 4'b0000, 4'd9},   // R9 idle ends drain, no flags
    {7'b1000000, 4'b1000, 4'd3},   // R3
    {7'b0010000, 4'b1100, 4'd6},   // R6 tx address received
    {7'b0000100, 4'b0001, 4'd12},  // R12/R7 NACKed byte ends drain, R8 no data
    {7'b1000000, 4'b1000, 4'd3},   // R3
    {7'b0001000, 4'b1100, 4'd6},   // R6 rx data at request
    {7'b1000000, 4'b1000, 4'd10},  // R10 cancel
    {7'b0000001, 4'b1000, 4'd10},  // R10 new drain has no residue
    {7'b0000001, 4'b0000, 4'd9}    // R9 idle shutdown
  };

  task automatic checkOut(input int tag, input logic eCore, input logic eNack,
                          input logic eLost, input logic eBusy);
    logic [StatusW-1:0] expWord;
    expWord = '0;
    expWord[0] = eCore;
    expWord[1] = eBusy;
    expWord[2] = eLost;
    checks++;
    if (coreEnable !== eCore || forceNack !== eNack || statusWord !== expWord) begin
      errors++;
      $display("FAIL R%0d: core=%b nack=%b status=%h expected core=%b nack=%b status=%h",
               tag, coreEnable, forceNack, statusWord, eCore, eNack, expWord);
    end
  endtask

  task automatic drive(input logic [6:0] v);
    {swEnable, slvAddrPhase, slvTxAddr, slvRxData, byteDone, stopSeen, busIdle} = v;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    drive(7'b0000001);
    repeat (3) @(negedge clk);
    checkOut(1, 1'b0, 1'b0, 1'b0, 1'b0);  // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1, 1'b0, 1'b0, 1'b0, 1'b0);  // R1 / R2 after reset

    for (int k = 0; k < NumVec; k++) begin
      @(negedge clk);
      drive(VEC[k][14:8]);
      @(posedge clk);
      #1;
      checkOut(int'(VEC[k][3:0]), VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4]);
    end

    // R12 directed: byteDone alone leaves core on during a non-busy drain
    @(negedge clk); drive(7'b1000000);
    @(negedge clk); drive(7'b0000000);
    @(negedge clk); drive(7'b0000100);
    @(posedge clk); #1;
    checkOut(12, 1'b1, 1'b0, 1'b0, 1'b0);

    // R1 directed: reset in the middle of a busy drain
    @(negedge clk); drive(7'b0001000);
    @(posedge clk); #1;
    checkOut(6, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b0;
    #1;
    checkOut(1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); drive(7'b0000001); rstN = 1'b1;
    @(negedge clk);
    checkOut(1, 1'b0, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule